// File: doc/BRIEF.md
# Parallel-to-Serial Output Converter

This block turns a parallel word into one serial bit stream for a source-synchronous transmit path. A slow word clock captures the word and a tristate request together. A fast bit clock then shifts the captured bits out on both of its edges, two bits per fast cycle, starting with the least-significant bit. When a new word has been captured, it waits in a holding register. It moves into the shifter only when the previous word's last bit pair has gone out, so the stream runs without gaps or corruption.

Single data rate output uses the same datapath. The width is set to 8 and the caller writes each of four bits twice into the word. Each bit then fills a whole fast-clock period. The tristate request follows the data through the same pipeline, so a change in it takes effect on the first bit of the word it was captured with. Parameters set the width (4 or 8), the value every flip-flop takes at reset, and the polarity of the bit clock, the word clock and the asynchronous reset.

The bit clock runs at WIDTH/2 times the word-clock rate. Its rising edges line up with the word-clock rising edges. Reset must be released between edges, before a common rising edge of the two clocks. That edge then becomes slot 0 of the word cadence.

Top module: `ptx_serializer`

## Requirements
- R1: WIDTH is 4 or 8 (default 8). Each word is sent as WIDTH consecutive bits, least-significant first: par_data[0] goes out first and par_data[WIDTH-1] last.
- R2: With the clock inversion parameters at 0, one bit is presented per half period of the bit clock. Bit 2k of a word is on ser_out while the bit clock is high, and bit 2k+1 during the low phase that follows.
- R3: par_data is captured on the word-clock edge. The first bit of that word appears at the bit-clock rising edge WIDTH/2-1 bit cycles after the capturing edge. Consecutive words then follow with no gap, one word every WIDTH/2 bit cycles.
- R4: Single data rate: with WIDTH=8 and each bit n written to par_data[2n] and par_data[2n+1], ser_out holds each of the four bits for one full bit-clock period, bit 0 first.
- R5: During reset, and afterwards until the first captured word starts, ser_out and tri_out both equal INIT_VAL.
- R6: Reset is asynchronous. Asserting it drives ser_out and tri_out to INIT_VAL with no clock edge. RST_INV=0 makes rst_in active-high and RST_INV=1 makes it active-low.
- R7: tri_out takes the tri_req value captured with a word, changes at the first bit of that word, and stays constant for all of that word's bits.
- R8: CLK_INV=1 and WORD_INV=1 make the block act on the falling edges of clk_bit_in and clk_word_in, with the same cycle-level behaviour relative to those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_in | input | 1 | Fast bit clock (polarity set by CLK_INV) |
| clk_word_in | input | 1 | Divided word clock (polarity set by WORD_INV) |
| rst_in | input | 1 | Asynchronous reset (polarity set by RST_INV) |
| par_data | input | WIDTH | Parallel word, bit 0 sent first |
| tri_req | input | 1 | Tristate request from the fabric |
| ser_out | output | 1 | Serial data toward the pad |
| tri_out | output | 1 | Tristate control aligned with ser_out |

## Verification
A phase counter that is off by one shifts every word boundary that follows. From the first word on, the bits of neighbouring words appear mixed at ser_out. A fault in the holding or shift registers shows within one word period, as a wrong bit in a specific half-cycle slot. A tristate path out of step with the data shows at the first bit of the word whose request changed. A reset that does not reach a flop shows in the first samples after release as a value other than INIT_VAL.

// File: rtl/ptx_pkg.sv
// Shared helpers for the parallel-to-serial transmitter.
// Assumes WIDTH is even (4 or 8); two bits leave per fast cycle.
package ptx_pkg;
    // Number of fast-clock cycles needed to send one word.
    function automatic int slots_per_word(input int width);
        return width / 2;
    endfunction

    // Counter width able to index every slot of a word.
    function automatic int phase_bits(input int slots);
        return (slots <= 2) ? 1 : $clog2(slots);
    endfunction
endpackage

// File: rtl/ptx_word_hold.sv
// Word-clock capture stage: holds the parallel word and the tristate
// request until the fast domain takes them.
// Assumes the fast domain reads only away from word-clock edges.
module ptx_word_hold #(
    parameter int   WIDTH    = 8,
    parameter logic INIT_VAL = 1'b0
) (
    input  logic             clk_word,
    input  logic             rst_act,
    input  logic [WIDTH-1:0] word_in,
    input  logic             tri_in,
    output logic [WIDTH-1:0] word_q,
    output logic             tri_q
);
    // Capture word and tristate request on every word-clock edge.
    always_ff @(posedge clk_word or posedge rst_act) begin
        if (rst_act) begin
            word_q <= {WIDTH{INIT_VAL}};
            tri_q  <= INIT_VAL;
        end else begin
            word_q <= word_in;
            tri_q  <= tri_in;
        end
    end
endmodule

// File: rtl/ptx_pair_shift.sv
// Fast-domain shifter: counts word slots, loads the held word on the
// last slot and emits one bit pair per cycle (even bit for the high
// phase, odd bit pending for the low phase).
// Assumes slot 0 coincides with a word-clock edge after reset release.
module ptx_pair_shift #(
    parameter int   WIDTH    = 8,
    parameter logic INIT_VAL = 1'b0
) (
    input  logic             clk_bit,
    input  logic             rst_act,
    input  logic [WIDTH-1:0] word_q,
    input  logic             tri_q,
    output logic             load_now,
    output logic             rise_bit,
    output logic             fall_pend,
    output logic             tri_bit
);
    localparam int SLOTS = ptx_pkg::slots_per_word(WIDTH);
    localparam int PW    = ptx_pkg::phase_bits(SLOTS);
    localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);

    logic [PW-1:0]    phase;
    logic [WIDTH-1:0] shreg;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] nxt;

    assign load_now = (phase == LAST_SLOT);
    assign src      = load_now ? word_q : shreg;

    // Advance the remaining bits by two, refilling the top with INIT_VAL.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        if (i < WIDTH - 2) begin : g_move
            assign nxt[i] = src[i + 2];
        end else begin : g_fill
            assign nxt[i] = INIT_VAL;
        end
    end

    // Slot counter that wraps once per word.
    always_ff @(posedge clk_bit or posedge rst_act) begin
        if (rst_act)       phase <= '0;
        else if (load_now) phase <= '0;
        else               phase <= phase + 1'b1;
    end

    // Present the next bit pair and retire it from the shift register.
    always_ff @(posedge clk_bit or posedge rst_act) begin
        if (rst_act) begin
            shreg     <= {WIDTH{INIT_VAL}};
            rise_bit  <= INIT_VAL;
            fall_pend <= INIT_VAL;
        end else begin
            shreg     <= nxt;
            rise_bit  <= src[0];
            fall_pend <= src[1];
        end
    end

    // Tristate follows the word into the output stage at load time.
    always_ff @(posedge clk_bit or posedge rst_act) begin
        if (rst_act)       tri_bit <= INIT_VAL;
        else if (load_now) tri_bit <= tri_q;
    end
endmodule

// File: rtl/ptx_ddr_out.sv
// Double-edge output stage: retimes the odd bit to the falling edge
// and selects between the two half-cycle bits by the clock level.
// Assumes rise_bit and fall_pend change only on the rising edge.
module ptx_ddr_out #(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk_bit,
    input  logic rst_act,
    input  logic rise_bit,
    input  logic fall_pend,
    output logic ser_out
);
    logic fall_q;

    // Move the odd bit onto the low half of the cycle.
    always_ff @(negedge clk_bit or posedge rst_act) begin
        if (rst_act) fall_q <= INIT_VAL;
        else         fall_q <= fall_pend;
    end

    assign ser_out = clk_bit ? rise_bit : fall_q;
endmodule

// File: rtl/ptx_serializer.sv
// Top of the parallel-to-serial transmitter: applies pin polarity,
// then chains word capture, pair shifter and double-edge output.
// Assumes the clock alignment and reset release described in the brief.
module ptx_serializer #(
    parameter int   WIDTH    = 8,
    parameter logic INIT_VAL = 1'b0,
    parameter logic CLK_INV  = 1'b0,
    parameter logic WORD_INV = 1'b0,
    parameter logic RST_INV  = 1'b0
) (
    input  logic             clk_bit_in,
    input  logic             clk_word_in,
    input  logic             rst_in,
    input  logic [WIDTH-1:0] par_data,
    input  logic             tri_req,
    output logic             ser_out,
    output logic             tri_out
);
    logic             clk_bit;
    logic             clk_word;
    logic             rst_act;
    logic [WIDTH-1:0] word_q;
    logic             tri_q;
    logic             load_now;
    logic             rise_bit;
    logic             fall_pend;

    assign clk_bit  = clk_bit_in  ^ CLK_INV;
    assign clk_word = clk_word_in ^ WORD_INV;
    assign rst_act  = rst_in      ^ RST_INV;

    ptx_word_hold #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_hold (
        .clk_word (clk_word),
        .rst_act  (rst_act),
        .word_in  (par_data),
        .tri_in   (tri_req),
        .word_q   (word_q),
        .tri_q    (tri_q)
    );

    ptx_pair_shift #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_shift (
        .clk_bit   (clk_bit),
        .rst_act   (rst_act),
        .word_q    (word_q),
        .tri_q     (tri_q),
        .load_now  (load_now),
        .rise_bit  (rise_bit),
        .fall_pend (fall_pend),
        .tri_bit   (tri_out)
    );

    ptx_ddr_out #(.INIT_VAL(INIT_VAL)) u_out (
        .clk_bit   (clk_bit),
        .rst_act   (rst_act),
        .rise_bit  (rise_bit),
        .fall_pend (fall_pend),
        .ser_out   (ser_out)
    );
endmodule

// File: rtl/ptx_chk.sv
// Property checker for ptx_serializer, attached by bind below.
// Assumes clk_bit and rst_act are the polarity-corrected internals.
module ptx_chk #(
    parameter int WIDTH = 8
) (
    input logic       clk_bit,
    input logic       rst_act,
    input logic       load_now,
    input logic [1:0] word_lo,
    input logic       tri_q,
    input logic       rise_bit,
    input logic       fall_pend,
    input logic       tri_out
);
    localparam int SLOTS = ptx_pkg::slots_per_word(WIDTH);

    int gap;

    // Count fast cycles since the last load, independently of the shifter.
    always_ff @(posedge clk_bit or posedge rst_act) begin
        if (rst_act)       gap <= 0;
        else if (load_now) gap <= 0;
        else               gap <= gap + 1;
    end

    // R3
    cadence_chk: assert property (@(posedge clk_bit) disable iff (rst_act)
        load_now |-> (gap == SLOTS - 1));

    // R1
    first_pair_chk: assert property (@(posedge clk_bit) disable iff (rst_act)
        load_now |=> (rise_bit == $past(word_lo[0])) && (fall_pend == $past(word_lo[1])));

    // R7
    tri_load_chk: assert property (@(posedge clk_bit) disable iff (rst_act)
        load_now |=> (tri_out == $past(tri_q)));

    // R7
    tri_hold_chk: assert property (@(posedge clk_bit) disable iff (rst_act)
        !load_now |=> $stable(tri_out));
endmodule

bind ptx_serializer ptx_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_bit   (clk_bit),
    .rst_act   (rst_act),
    .load_now  (load_now),
    .word_lo   (word_q[1:0]),
    .tri_q     (tri_q),
    .rise_bit  (rise_bit),
    .fall_pend (fall_pend),
    .tri_out   (tri_out)
);

// File: tb/sim_ptx_serializer.sv
`timescale 1ns/100ps
module sim_ptx_serializer;
    localparam int N8 = 272;   // 256 exhaustive DDR words + 16 SDR words
    localparam int N4 = 544;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    int   hs    = 0;
    logic clk = 0, div8 = 0, div4 = 0, rst = 1, go = 0;
    logic [7:0] d8;
    logic       t8;
    logic [3:0] d4;
    logic       t4;
    logic       oq8, to8, oq4, to4;

    // 100 MHz bit clock; word clocks rise together with it.
    always #5 begin
        hs++;
        clk  = hs[0];
        div8 = ((hs - 1) % 8) < 4;
        div4 = ((hs - 1) % 4) < 2;
    end

    ptx_serializer #(.WIDTH(8), .INIT_VAL(1'b0)) u0 (
        .clk_bit_in(clk), .clk_word_in(div8), .rst_in(rst),
        .par_data(d8), .tri_req(t8), .ser_out(oq8), .tri_out(to8));

    ptx_serializer #(.WIDTH(4), .INIT_VAL(1'b1), .CLK_INV(1'b1),
                     .WORD_INV(1'b1), .RST_INV(1'b1)) u1 (
        .clk_bit_in(~clk), .clk_word_in(~div4), .rst_in(~rst),
        .par_data(d4), .tri_req(t4), .ser_out(oq4), .tri_out(to4));

    function automatic logic [7:0] word8(int j);
        logic [7:0] w;
        if (j < 256) return j[7:0];
        for (int n = 0; n < 4; n++) begin
            w[2*n]   = ((j - 256) >> n) & 1;
            w[2*n+1] = ((j - 256) >> n) & 1;
        end
        return w;
    endfunction
    function automatic logic tri8(int j); return (j % 3) == 0; endfunction
    function automatic logic [3:0] word4(int j); return 4'((j * 7) % 16); endfunction
    function automatic logic tri4(int j); return (j % 5) == 1; endfunction

    task automatic check(string req, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
        end
    endtask

    task automatic at_time(realtime t);
        if (t > $realtime) #(t - $realtime);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Word drivers: next word presented 1 ns after each capturing edge.
    initial begin
        d8 = word8(0); t8 = tri8(0);
        wait (go);
        for (int j = 1; j < N8; j++) begin
            @(posedge div8); #1;
            d8 = word8(j); t8 = tri8(j);
        end
    end
    initial begin
        d4 = word4(0); t4 = tri4(0);
        wait (go);
        for (int j = 1; j < N4; j++) begin
            @(posedge div4); #1;
            d4 = word4(j); t4 = tri4(j);
        end
    end

    // Width-8 stream: word j bit b is centred at 237.5 + 40j + 5b.
    task automatic stream8();
        for (int j = 0; j < N8; j++) begin
            for (int b = 0; b < 8; b++) begin
                at_time(237.5 + 40.0 * j + 5.0 * b);
                if (j < 256)
                    check(b % 2 ? "R1 R2 R3 low phase" : "R1 R2 R3 high phase",
                          oq8, 1'((j >> b) & 1));
                else
                    check("R4 single-rate bit", oq8, 1'(((j - 256) >> (b / 2)) & 1));
                check("R7 tristate u0", to8, (j % 3) == 0);
            end
        end
    endtask

    // Width-4 inverted-pin stream: word j bit b centred at 217.5 + 20j + 5b.
    task automatic stream4();
        for (int j = 0; j < N4; j++) begin
            for (int b = 0; b < 4; b++) begin
                at_time(217.5 + 20.0 * j + 5.0 * b);
                check("R8 R1 R3 inverted pins", oq4, 1'((((j * 7) % 16) >> b) & 1));
                check("R8 R7 tristate u1", to4, (j % 5) == 1);
            end
        end
    endtask

    initial begin
        #100;
        check("R5 reset ser u0", oq8, 1'b0);
        check("R5 reset tri u0", to8, 1'b0);
        check("R5 reset ser u1", oq4, 1'b1);
        check("R6 R5 active-low reset tri u1", to4, 1'b1);
        at_time(202.0);
        rst = 0; go = 1;
        at_time(207.5);
        check("R5 pre-load ser u0", oq8, 1'b0);
        check("R5 pre-load ser u1", oq4, 1'b1);
        check("R5 pre-load tri u1", to4, 1'b1);
        at_time(222.5);
        check("R5 pre-load ser u0 late", oq8, 1'b0);
        check("R5 pre-load tri u0", to8, 1'b0);
        fork
            stream8();
            stream4();
        join
        #3 rst = 1;
        #1;
        check("R6 async reset ser u0", oq8, 1'b0);
        check("R6 async reset tri u0", to8, 1'b0);
        check("R6 async reset ser u1", oq4, 1'b1);
        check("R6 async reset tri u1", to4, 1'b1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule